// File: doc/BRIEF.md
# Flash command decoder

This block is the command front end of a NOR-style flash, written as a synchronous model. The host bus presents write cycles, each an address and a 16-bit word. The decoder reads the opcode from the low byte of the word. Some commands take one cycle. Others are two-cycle setup/confirm pairs. The decoder remembers which source drives the read path: the memory array, the identifier space, the query space or the status byte. It sends start, suspend and resume requests to a separate write engine, and the engine reports back through a busy flag.

Sector lock state lives in a small lock table inside the block. Lock, unlock and lock-down commands act on that table directly. Erase, word write and protection-register write are handed to the engine with their address and data.

The read port has a latency of one clock. A status read captures the status byte when the read strobe rises and holds it until the strobe drops. Array data comes from an external array port. The query space is a small stub table.

Top module: `flash_cmd_decoder`

## Requirements
- R1: After synchronous reset the read source is the array, no sequence is pending, no error or suspend bit is set, and no engine request is raised. `rd_data` reflects the selected source one clock after `rd_en` is sampled high, and is zero one clock after `rd_en` is sampled low.
- R2: The opcode is `wr_data[7:0]`, and the upper byte of a command word is ignored. FFH selects the array, 90H the identifier space, 98H the query space and 70H the status byte. A read that starts in the same clock as a mode-changing write uses the mode in force before that write.
- R3: Reads from the identifier space:
  - Address 0 returns 00C2H.
  - Address 1 returns 88C2H when `TOP_BOOT`=1, or 88C3H otherwise.
  - Any address whose in-sector offset (all bits below the top three) equals 2 returns `{14'b0, locked_down, locked}` for the sector named by the top three address bits.
  - Every other address reads as zero.
  Reads from the query space return 0051H, 0052H and 0059H at addresses 10H, 11H and 12H, and zero elsewhere.
- R4: 20H followed by D0H pulses `eng_start` for one clock with `eng_op`=1 and the second cycle's address. The read source then becomes the status byte.
- R5: Word write uses 40H or 10H, and protection-register write uses C0H. Either setup followed by any word pulses `eng_start`, with `eng_op`=2 for word write or 3 for protection write, carrying that word's address and data. The read source becomes status.
- R6: 60H opens a lock sequence, and the second word acts on the sector in its top three address bits. 01H locks the sector and 2FH locks it down. D0H unlocks it, unless the sector is locked down. The read source becomes status, and no engine request is raised.
- R7: If the second cycle of an erase or lock sequence carries any other code, the sequence is dropped, status bits 5 and 4 are both set, and the read source becomes status. 50H clears those bits when the engine is idle and nothing is suspended.
- R8: While `eng_busy` is high and nothing is suspended, only 70H and B0H take effect. FFH, 90H, 98H, 50H and every setup opcode are ignored.
- R9: B0H while the engine runs pulses `eng_suspend` and makes the read source status. D0H while suspended pulses `eng_resume`, clears the suspend state and makes the read source status. B0H has no effect when the engine is idle.
- R10: While suspended, FFH, 90H, 98H and 70H switch the read source. 50H and all setup opcodes are ignored.
- R11: The status byte sits in `rd_data[7:0]`, and the upper byte is zero. The bits are:
  - Bit 7: ready, meaning `eng_busy` is low or an operation is suspended.
  - Bit 6: erase suspended.
  - Bits 5 and 4: sequence error.
  - Bit 2: word or protection write suspended.
  - All other bits are zero.
- R12: In status mode the value is captured in the clock where `rd_en` is first sampled high. It is held unchanged while `rd_en` stays high.
- R13: A first-cycle opcode outside the command set changes nothing.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous reset, active high |
| wr_en | input | 1 | Bus write cycle strobe |
| wr_addr | input | ADDR_W | Write cycle address |
| wr_data | input | DATA_W | Write cycle data, opcode in low byte |
| rd_en | input | 1 | Read strobe, level |
| rd_addr | input | ADDR_W | Read address |
| arr_data | input | DATA_W | Word from the array for the current read address |
| rd_data | output | DATA_W | Registered read data |
| eng_busy | input | 1 | Write engine busy |
| eng_start | output | 1 | One-clock start request |
| eng_op | output | 2 | Operation kind: 1 erase, 2 word, 3 protection |
| eng_addr | output | ADDR_W | Address for the started operation |
| eng_data | output | DATA_W | Data for the started operation |
| eng_suspend | output | 1 | One-clock suspend request |
| eng_resume | output | 1 | One-clock resume request |

## Verification
A read can begin in the same clock that a command write changes the read source or the error bits. The bench provokes this on purpose: it raises `rd_en` in the clock that 70H is written while the array is the source. It then expects the array word, because the read uses the mode in force before the write. A second collision is an engine busy change while a status read is held open. There the bench expects the captured byte to stay until the strobe is dropped and raised again. Random command streams mixed with busy toggles are compared word by word against a bench model of the requirements.

// File: rtl/fcd_pkg.sv
package fcd_pkg;

    typedef enum logic [1:0] {
        RM_ARRAY  = 2'd0,
        RM_IDENT  = 2'd1,
        RM_QUERY  = 2'd2,
        RM_STATUS = 2'd3
    } rd_mode_e;

    typedef enum logic [2:0] {
        PD_NONE  = 3'd0,
        PD_ERASE = 3'd1,
        PD_WORD  = 3'd2,
        PD_PROT  = 3'd3,
        PD_LOCK  = 3'd4
    } pend_e;

    typedef enum logic [1:0] {
        OP_NONE  = 2'd0,
        OP_ERASE = 2'd1,
        OP_WORD  = 2'd2,
        OP_PROT  = 2'd3
    } eng_op_e;

    typedef enum logic [1:0] {
        LK_SET  = 2'd0,
        LK_CLR  = 2'd1,
        LK_DOWN = 2'd2
    } lock_code_e;

    localparam logic [7:0] CMD_ARRAY   = 8'hFF;
    localparam logic [7:0] CMD_IDENT   = 8'h90;
    localparam logic [7:0] CMD_QUERY   = 8'h98;
    localparam logic [7:0] CMD_STAT    = 8'h70;
    localparam logic [7:0] CMD_CLR     = 8'h50;
    localparam logic [7:0] CMD_ERASE   = 8'h20;
    localparam logic [7:0] CMD_WORD_A  = 8'h40;
    localparam logic [7:0] CMD_WORD_B  = 8'h10;
    localparam logic [7:0] CMD_LOCK    = 8'h60;
    localparam logic [7:0] CMD_PROT    = 8'hC0;
    localparam logic [7:0] CMD_SUSP    = 8'hB0;
    localparam logic [7:0] CMD_GO      = 8'hD0;
    localparam logic [7:0] CMD_LK_SET  = 8'h01;
    localparam logic [7:0] CMD_LK_DOWN = 8'h2F;

    localparam logic [15:0] MFR_CODE = 16'h00C2;
    localparam logic [15:0] DEV_TOP  = 16'h88C2;
    localparam logic [15:0] DEV_BOT  = 16'h88C3;

    // Status byte layout: ready, erase suspend, err hi, err lo, 0, prog suspend, 0, 0
    function automatic logic [7:0] pack_status(input logic ready,
                                               input logic esusp,
                                               input logic [1:0] err,
                                               input logic psusp);
        return {ready, esusp, err, 1'b0, psusp, 2'b00};
    endfunction

    // Stub query table
    function automatic logic [15:0] query_word(input logic [7:0] off);
        case (off)
            8'h10:   return 16'h0051;
            8'h11:   return 16'h0052;
            8'h12:   return 16'h0059;
            default: return 16'h0000;
        endcase
    endfunction

endpackage

// File: rtl/fcd_seq.sv
module fcd_seq
    import fcd_pkg::*;
#(
    parameter int ADDR_W = 20,
    parameter int DATA_W = 16,
    parameter int SECT_W = 3
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              wr_en,
    input  logic [ADDR_W-1:0] wr_addr,
    input  logic [DATA_W-1:0] wr_data,
    input  logic              eng_busy,
    output rd_mode_e          mode,
    output logic [7:0]        status,
    output logic              eng_start,
    output eng_op_e           eng_op,
    output logic [ADDR_W-1:0] eng_addr,
    output logic [DATA_W-1:0] eng_data,
    output logic              eng_suspend,
    output logic              eng_resume,
    output logic              lock_we,
    output lock_code_e        lock_code,
    output logic [SECT_W-1:0] lock_sect
);

    logic [7:0] op;
    logic       running;
    logic       idle;

    rd_mode_e   mode_q, mode_d;
    pend_e      pend_q, pend_d;
    logic       susp_q, susp_d;
    eng_op_e    cur_q, cur_d;
    logic [1:0] err_q, err_d;
    logic       start_d, susp_p, res_p, bad;
    eng_op_e    sop;

    assign op        = wr_data[7:0];
    assign running   = eng_busy && !susp_q;
    assign idle      = !eng_busy && !susp_q;
    assign lock_sect = wr_addr[ADDR_W-1 -: SECT_W];

    always_comb begin
        mode_d    = mode_q;
        pend_d    = pend_q;
        susp_d    = susp_q;
        cur_d     = cur_q;
        err_d     = err_q;
        start_d   = 1'b0;
        susp_p    = 1'b0;
        res_p     = 1'b0;
        bad       = 1'b0;
        sop       = OP_NONE;
        lock_we   = 1'b0;
        lock_code = LK_SET;
        if (wr_en) begin
            if (pend_q != PD_NONE) begin
                pend_d = PD_NONE;
                case (pend_q)
                    PD_ERASE: begin
                        if (op == CMD_GO) begin
                            start_d = 1'b1;
                            sop     = OP_ERASE;
                        end else begin
                            bad = 1'b1;
                        end
                    end
                    PD_WORD: begin
                        start_d = 1'b1;
                        sop     = OP_WORD;
                    end
                    PD_PROT: begin
                        start_d = 1'b1;
                        sop     = OP_PROT;
                    end
                    PD_LOCK: begin
                        mode_d = RM_STATUS;
                        if (op == CMD_LK_SET) begin
                            lock_we   = 1'b1;
                            lock_code = LK_SET;
                        end else if (op == CMD_GO) begin
                            lock_we   = 1'b1;
                            lock_code = LK_CLR;
                        end else if (op == CMD_LK_DOWN) begin
                            lock_we   = 1'b1;
                            lock_code = LK_DOWN;
                        end else begin
                            bad = 1'b1;
                        end
                    end
                    default: ;
                endcase
                if (start_d) begin
                    mode_d = RM_STATUS;
                    cur_d  = sop;
                end
                if (bad) begin
                    err_d  = 2'b11;
                    mode_d = RM_STATUS;
                end
            end else begin
                case (op)
                    CMD_ARRAY:  if (!running) mode_d = RM_ARRAY;
                    CMD_IDENT:  if (!running) mode_d = RM_IDENT;
                    CMD_QUERY:  if (!running) mode_d = RM_QUERY;
                    CMD_STAT:   mode_d = RM_STATUS;
                    CMD_CLR:    if (idle) err_d = 2'b00;
                    CMD_ERASE:  if (idle) pend_d = PD_ERASE;
                    CMD_WORD_A,
                    CMD_WORD_B: if (idle) pend_d = PD_WORD;
                    CMD_PROT:   if (idle) pend_d = PD_PROT;
                    CMD_LOCK:   if (idle) pend_d = PD_LOCK;
                    CMD_SUSP: begin
                        if (running) begin
                            susp_d = 1'b1;
                            susp_p = 1'b1;
                            mode_d = RM_STATUS;
                        end
                    end
                    CMD_GO: begin
                        if (susp_q) begin
                            susp_d = 1'b0;
                            res_p  = 1'b1;
                            mode_d = RM_STATUS;
                        end
                    end
                    default: ;
                endcase
            end
        end
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            mode_q      <= RM_ARRAY;
            pend_q      <= PD_NONE;
            susp_q      <= 1'b0;
            cur_q       <= OP_NONE;
            err_q       <= 2'b00;
            eng_start   <= 1'b0;
            eng_suspend <= 1'b0;
            eng_resume  <= 1'b0;
            eng_op      <= OP_NONE;
            eng_addr    <= '0;
            eng_data    <= '0;
        end else begin
            mode_q      <= mode_d;
            pend_q      <= pend_d;
            susp_q      <= susp_d;
            cur_q       <= cur_d;
            err_q       <= err_d;
            eng_start   <= start_d;
            eng_suspend <= susp_p;
            eng_resume  <= res_p;
            if (start_d) begin
                eng_op   <= sop;
                eng_addr <= wr_addr;
                eng_data <= wr_data;
            end
        end
    end

    assign mode   = mode_q;
    assign status = pack_status(!eng_busy || susp_q,
                                susp_q && (cur_q == OP_ERASE),
                                err_q,
                                susp_q && ((cur_q == OP_WORD) || (cur_q == OP_PROT)));

    // R8
    ff_blocked_chk: assert property (@(posedge clk) disable iff (rst)
        (wr_en && pend_q == PD_NONE && op == CMD_ARRAY && eng_busy && !susp_q)
        |=> mode_q == $past(mode_q));

    // R7
    bad_confirm_chk: assert property (@(posedge clk) disable iff (rst)
        (wr_en && pend_q == PD_ERASE && op != CMD_GO)
        |=> (err_q == 2'b11 && mode_q == RM_STATUS && !eng_start));

    // R9
    req_onehot_chk: assert property (@(posedge clk) disable iff (rst)
        $onehot0({eng_start, eng_suspend, eng_resume}));

    // R4
    start_status_chk: assert property (@(posedge clk) disable iff (rst)
        eng_start |-> (mode_q == RM_STATUS && !susp_q));

    // R9
    resume_after_susp_chk: assert property (@(posedge clk) disable iff (rst)
        eng_resume |-> (!susp_q && $past(susp_q)));

endmodule

// File: rtl/fcd_lock_table.sv
module fcd_lock_table
    import fcd_pkg::*;
#(
    parameter int SECT_W = 3
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              we,
    input  lock_code_e        code,
    input  logic [SECT_W-1:0] sect,
    output logic [(1<<SECT_W)-1:0] lock_vec,
    output logic [(1<<SECT_W)-1:0] down_vec
);

    localparam int NSECT = 1 << SECT_W;

    for (genvar g = 0; g < NSECT; g++) begin : g_sect
        always_ff @(posedge clk) begin
            if (rst) begin
                lock_vec[g] <= 1'b0;
                down_vec[g] <= 1'b0;
            end else if (we && sect == SECT_W'(g)) begin
                case (code)
                    LK_SET:  lock_vec[g] <= 1'b1;
                    LK_CLR:  if (!down_vec[g]) lock_vec[g] <= 1'b0;
                    LK_DOWN: begin
                        lock_vec[g] <= 1'b1;
                        down_vec[g] <= 1'b1;
                    end
                    default: ;
                endcase
            end
        end
    end

    // R6
    down_implies_lock_chk: assert property (@(posedge clk) disable iff (rst)
        (down_vec & ~lock_vec) == '0);

endmodule

// File: rtl/fcd_read_mux.sv
module fcd_read_mux
    import fcd_pkg::*;
#(
    parameter int ADDR_W   = 20,
    parameter int DATA_W   = 16,
    parameter int SECT_W   = 3,
    parameter bit TOP_BOOT = 1'b1
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              rd_en,
    input  logic [ADDR_W-1:0] rd_addr,
    input  logic [DATA_W-1:0] arr_data,
    input  rd_mode_e          mode,
    input  logic [7:0]        status,
    input  logic [(1<<SECT_W)-1:0] lock_vec,
    input  logic [(1<<SECT_W)-1:0] down_vec,
    output logic [DATA_W-1:0] rd_data
);

    localparam int OFF_W = ADDR_W - SECT_W;
    localparam logic [15:0] DEV_CODE = TOP_BOOT ? DEV_TOP : DEV_BOT;

    logic [SECT_W-1:0] sect;
    logic [OFF_W-1:0]  off;
    logic [DATA_W-1:0] src;
    logic              rd_q;

    assign sect = rd_addr[ADDR_W-1 -: SECT_W];
    assign off  = rd_addr[OFF_W-1:0];

    always_comb begin
        src = '0;
        case (mode)
            RM_ARRAY: src = arr_data;
            RM_IDENT: begin
                if (rd_addr == '0)
                    src = DATA_W'(MFR_CODE);
                else if (rd_addr == ADDR_W'(1))
                    src = DATA_W'(DEV_CODE);
                else if (off == OFF_W'(2))
                    src = DATA_W'({down_vec[sect], lock_vec[sect]});
            end
            RM_QUERY: begin
                if (rd_addr[ADDR_W-1:8] == '0)
                    src = DATA_W'(query_word(rd_addr[7:0]));
            end
            RM_STATUS: src = DATA_W'(status);
            default: ;
        endcase
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            rd_q    <= 1'b0;
            rd_data <= '0;
        end else begin
            rd_q <= rd_en;
            if (!rd_en)
                rd_data <= '0;
            else if (mode != RM_STATUS || !rd_q)
                rd_data <= src;
        end
    end

    // R12
    status_hold_chk: assert property (@(posedge clk) disable iff (rst)
        (rd_en && rd_q && mode == RM_STATUS) |=> $stable(rd_data));

    // R1
    idle_zero_chk: assert property (@(posedge clk) disable iff (rst)
        !rd_en |=> rd_data == '0);

endmodule

// File: rtl/flash_cmd_decoder.sv
module flash_cmd_decoder
    import fcd_pkg::*;
#(
    parameter int ADDR_W   = 20,
    parameter int DATA_W   = 16,
    parameter int SECT_W   = 3,
    parameter bit TOP_BOOT = 1'b1
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              wr_en,
    input  logic [ADDR_W-1:0] wr_addr,
    input  logic [DATA_W-1:0] wr_data,
    input  logic              rd_en,
    input  logic [ADDR_W-1:0] rd_addr,
    input  logic [DATA_W-1:0] arr_data,
    output logic [DATA_W-1:0] rd_data,
    input  logic              eng_busy,
    output logic              eng_start,
    output logic [1:0]        eng_op,
    output logic [ADDR_W-1:0] eng_addr,
    output logic [DATA_W-1:0] eng_data,
    output logic              eng_suspend,
    output logic              eng_resume
);

    localparam int NSECT = 1 << SECT_W;

    rd_mode_e          mode;
    logic [7:0]        status;
    eng_op_e           op_e;
    logic              lock_we;
    lock_code_e        lock_code;
    logic [SECT_W-1:0] lock_sect;
    logic [NSECT-1:0]  lock_vec;
    logic [NSECT-1:0]  down_vec;

    fcd_seq #(.ADDR_W(ADDR_W), .DATA_W(DATA_W), .SECT_W(SECT_W)) u_seq (
        .clk(clk), .rst(rst),
        .wr_en(wr_en), .wr_addr(wr_addr), .wr_data(wr_data),
        .eng_busy(eng_busy),
        .mode(mode), .status(status),
        .eng_start(eng_start), .eng_op(op_e),
        .eng_addr(eng_addr), .eng_data(eng_data),
        .eng_suspend(eng_suspend), .eng_resume(eng_resume),
        .lock_we(lock_we), .lock_code(lock_code), .lock_sect(lock_sect)
    );

    fcd_lock_table #(.SECT_W(SECT_W)) u_locks (
        .clk(clk), .rst(rst),
        .we(lock_we), .code(lock_code), .sect(lock_sect),
        .lock_vec(lock_vec), .down_vec(down_vec)
    );

    fcd_read_mux #(.ADDR_W(ADDR_W), .DATA_W(DATA_W), .SECT_W(SECT_W),
                   .TOP_BOOT(TOP_BOOT)) u_rd (
        .clk(clk), .rst(rst),
        .rd_en(rd_en), .rd_addr(rd_addr), .arr_data(arr_data),
        .mode(mode), .status(status),
        .lock_vec(lock_vec), .down_vec(down_vec),
        .rd_data(rd_data)
    );

    assign eng_op = op_e;

endmodule

// File: tb/flash_cmd_decoder_bench.sv
module flash_cmd_decoder_bench;

    localparam int CLK_PERIOD = 10;
    localparam int NSECT      = 8;

    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic        wr_en = 1'b0;
    logic [19:0] wr_addr = '0;
    logic [15:0] wr_data = '0;
    logic        rd_en = 1'b0;
    logic [19:0] rd_addr = '0;
    logic [15:0] arr_data;
    logic [15:0] rd_data;
    logic        busy = 1'b0;
    logic        eng_start, eng_suspend, eng_resume;
    logic [1:0]  eng_op;
    logic [19:0] eng_addr;
    logic [15:0] eng_data;

    int checks = 0;
    int errors = 0;
    bit done = 1'b0;

    // bench model
    int       m_mode = 0;  // 0 array, 1 ident, 2 query, 3 status
    int       m_pend = 0;  // 0 none, 1 erase, 2 word, 3 prot, 4 lock
    bit       m_susp = 1'b0;
    int       m_cur  = 0;
    bit [1:0] m_err  = 2'b00;
    bit       m_lk[NSECT];
    bit       m_dn[NSECT];

    assign arr_data = rd_addr[15:0] ^ 16'hA5A5;

    always #(CLK_PERIOD/2) clk = ~clk;

    flash_cmd_decoder u_flash_cmd_decoder (
        .clk(clk), .rst(rst),
        .wr_en(wr_en), .wr_addr(wr_addr), .wr_data(wr_data),
        .rd_en(rd_en), .rd_addr(rd_addr), .arr_data(arr_data),
        .rd_data(rd_data),
        .eng_busy(busy), .eng_start(eng_start), .eng_op(eng_op),
        .eng_addr(eng_addr), .eng_data(eng_data),
        .eng_suspend(eng_suspend), .eng_resume(eng_resume)
    );

    task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s actual=%h expected=%h", req, act, exp);
        end
    endtask

    function automatic logic [7:0] exp_sr();
        return {(!busy || m_susp), (m_susp && m_cur == 1), m_err, 1'b0,
                (m_susp && (m_cur == 2 || m_cur == 3)), 2'b00};
    endfunction

    function automatic logic [15:0] exp_rd(input logic [19:0] a);
        case (m_mode)
            0: return a[15:0] ^ 16'hA5A5;
            1: begin
                if (a == 20'd0) return 16'h00C2;
                if (a == 20'd1) return 16'h88C2;
                if (a[16:0] == 17'd2) return {14'd0, m_dn[a[19:17]], m_lk[a[19:17]]};
                return 16'h0000;
            end
            2: begin
                if (a == 20'h10) return 16'h0051;
                if (a == 20'h11) return 16'h0052;
                if (a == 20'h12) return 16'h0059;
                return 16'h0000;
            end
            default: return {8'h00, exp_sr()};
        endcase
    endfunction

    task automatic do_write(input logic [19:0] a, input logic [15:0] d, input string req);
        logic [7:0] op;
        bit e_start, e_susp, e_res, bad, running, idle;
        int e_op, p, s;
        op = d[7:0];
        e_start = 0; e_susp = 0; e_res = 0; bad = 0; e_op = 0;
        running = busy && !m_susp;
        idle    = !busy && !m_susp;
        if (m_pend != 0) begin
            p = m_pend;
            m_pend = 0;
            case (p)
                1: if (op == 8'hD0) begin e_start = 1; e_op = 1; end else bad = 1;
                2: begin e_start = 1; e_op = 2; end
                3: begin e_start = 1; e_op = 3; end
                default: begin
                    s = int'(a[19:17]);
                    m_mode = 3;
                    if (op == 8'h01) m_lk[s] = 1;
                    else if (op == 8'hD0) begin if (!m_dn[s]) m_lk[s] = 0; end
                    else if (op == 8'h2F) begin m_lk[s] = 1; m_dn[s] = 1; end
                    else bad = 1;
                end
            endcase
            if (e_start) begin m_mode = 3; m_cur = e_op; end
            if (bad) begin m_err = 2'b11; m_mode = 3; end
        end else begin
            case (op)
                8'hFF: if (!running) m_mode = 0;
                8'h90: if (!running) m_mode = 1;
                8'h98: if (!running) m_mode = 2;
                8'h70: m_mode = 3;
                8'h50: if (idle) m_err = 2'b00;
                8'h20: if (idle) m_pend = 1;
                8'h40, 8'h10: if (idle) m_pend = 2;
                8'hC0: if (idle) m_pend = 3;
                8'h60: if (idle) m_pend = 4;
                8'hB0: if (running) begin m_susp = 1; e_susp = 1; m_mode = 3; end
                8'hD0: if (m_susp) begin m_susp = 0; e_res = 1; m_mode = 3; end
                default: ;
            endcase
        end
        wr_en = 1'b1; wr_addr = a; wr_data = d;
        @(posedge clk);
        @(negedge clk);
        wr_en = 1'b0;
        check({req, " start"}, {31'd0, eng_start}, {31'd0, e_start});
        check({req, " suspend"}, {31'd0, eng_suspend}, {31'd0, e_susp});
        check({req, " resume"}, {31'd0, eng_resume}, {31'd0, e_res});
        if (e_start) begin
            check({req, " op"}, {30'd0, eng_op}, e_op);
            check({req, " addr/data"}, {eng_addr[15:0], eng_data}, {a[15:0], d});
            busy = 1'b1;
        end
    endtask

    task automatic do_read(input logic [19:0] a, input string req);
        logic [15:0] e;
        e = exp_rd(a);
        rd_en = 1'b1; rd_addr = a;
        @(posedge clk);
        @(negedge clk);
        check(req, {16'd0, rd_data}, {16'd0, e});
        rd_en = 1'b0;
        @(posedge clk);
        @(negedge clk);
    endtask

    task automatic tick();
        @(posedge clk);
        @(negedge clk);
    endtask

    function automatic logic [7:0] pick_op();
        case ($urandom % 16)
            0: return 8'hFF;   1: return 8'h90;   2: return 8'h98;  3: return 8'h70;
            4: return 8'h50;   5: return 8'h20;   6: return 8'h40;  7: return 8'h10;
            8: return 8'h60;   9: return 8'hC0;   10: return 8'hB0; 11: return 8'hD0;
            12: return 8'h01;  13: return 8'h2F;  14: return 8'hD0;
            default: return 8'($urandom);
        endcase
    endfunction

    function automatic logic [19:0] pick_raddr();
        logic [19:0] a;
        a = 20'($urandom);
        case ($urandom % 6)
            0: return 20'd0;
            1: return 20'd1;
            2: return {a[19:17], 17'd2};
            3: return 20'h10 + 20'($urandom % 4);
            default: return a;
        endcase
    endfunction

    initial begin
        #(CLK_PERIOD * 100000);
        if (!done) begin
            errors++;
            $display("FAIL watchdog expired");
            $display("CHECKS %0d ERRORS %0d", checks, errors);
            $finish;
        end
    end

    initial begin
        void'($urandom(32'd20240517));
        for (int i = 0; i < NSECT; i++) begin m_lk[i] = 0; m_dn[i] = 0; end
        repeat (3) @(negedge clk);
        rst = 1'b0;
        tick();
        // R1 reset state
        check("R1 rd_data after reset", {16'd0, rd_data}, 32'd0);
        check("R1 no request after reset", {29'd0, eng_start, eng_suspend, eng_resume}, 32'd0);
        do_read(20'h01234, "R1 array read after reset");
        check("R1 idle read data zero", {16'd0, rd_data}, 32'd0);

        // R2 / R3 identifier space, upper byte ignored
        do_write(20'h0, 16'h3490, "R2 ident select");
        do_read(20'h00000, "R3 manufacturer code");
        do_read(20'h00001, "R3 device code");
        do_read(20'h000A3, "R3 ident other offset");
        do_write(20'h0, 16'h0098, "R2 query select");
        do_read(20'h00010, "R3 query 10");
        do_read(20'h00012, "R3 query 12");
        do_read(20'h00013, "R3 query 13");
        // R13 unknown opcode
        do_write(20'h0, 16'h0077, "R13 unknown opcode");
        do_read(20'h00011, "R13 mode kept after unknown opcode");

        // R6 lock table
        do_write(20'h0, 16'h0060, "R6 lock setup");
        do_write({3'd5, 17'h00400}, 16'h0001, "R6 lock sector 5");
        do_read(20'h0, "R6 status after lock");
        do_write(20'h0, 16'h0090, "R6 ident");
        do_read({3'd5, 17'd2}, "R6 sector 5 locked");
        do_write(20'h0, 16'h0060, "R6 lock setup");
        do_write({3'd2, 17'h00010}, 16'h002F, "R6 lock-down sector 2");
        do_write(20'h0, 16'h0060, "R6 lock setup");
        do_write({3'd2, 17'h00000}, 16'h00D0, "R6 unlock ignored on locked-down");
        do_write(20'h0, 16'h0060, "R6 lock setup");
        do_write({3'd5, 17'h00000}, 16'h00D0, "R6 unlock sector 5");
        do_write(20'h0, 16'h0090, "R6 ident");
        do_read({3'd2, 17'd2}, "R6 sector 2 locked-down");
        do_read({3'd5, 17'd2}, "R6 sector 5 unlocked");

        // R7 bad confirm codes and clear
        do_write(20'h0, 16'h0020, "R7 erase setup");
        do_write(20'h0, 16'h0055, "R7 bad erase confirm");
        do_read(20'h0, "R7 status after bad confirm");
        do_write(20'h0, 16'h0050, "R7 clear status");
        do_read(20'h0, "R7 status cleared");
        do_write(20'h0, 16'h0060, "R7 lock setup");
        do_write(20'h0, 16'h0044, "R7 bad lock confirm");
        do_read(20'h0, "R7 status after bad lock confirm");

        // R4 erase start, R8 blocked commands
        do_write(20'h0, 16'h0020, "R4 erase setup");
        do_write(20'h41234, 16'h00D0, "R4 erase confirm");
        do_read(20'h0, "R11 status while running");
        do_write(20'h0, 16'h00FF, "R8 array blocked");
        do_read(20'h0, "R8 still status after FF");
        do_write(20'h0, 16'h0090, "R8 ident blocked");
        do_write(20'h0, 16'h0050, "R8 clear blocked");
        do_write(20'h0, 16'h0040, "R8 setup blocked");
        do_write(20'h00100, 16'h00D0, "R8 no start from blocked setup");
        do_read(20'h0, "R8 status unchanged");

        // R9 suspend, R10 commands during suspend
        do_write(20'h0, 16'h00B0, "R9 suspend erase");
        do_read(20'h0, "R9 status erase suspended");
        do_write(20'h0, 16'h00FF, "R10 array during suspend");
        do_read(20'h00123, "R10 array read during suspend");
        do_write(20'h0, 16'h0070, "R10 status during suspend");
        do_write(20'h0, 16'h0050, "R10 clear ignored in suspend");
        do_read(20'h0, "R10 errors kept in suspend");
        do_write(20'h0, 16'h00D0, "R9 resume");
        do_read(20'h0, "R9 status after resume");
        busy = 1'b0;
        do_read(20'h0, "R11 ready after engine done");
        do_write(20'h0, 16'h0050, "R7 clear when idle");
        do_write(20'h0, 16'h00B0, "R9 suspend ignored when idle");
        do_read(20'h0, "R9 status idle");

        // R5 word and protection writes
        do_write(20'h0, 16'h0010, "R5 word setup 10");
        do_write(20'h02345, 16'hBEEF, "R5 word data");
        do_write(20'h0, 16'h00B0, "R9 suspend word");
        do_read(20'h0, "R9 status word suspended");
        do_write(20'h0, 16'h00D0, "R9 resume word");
        busy = 1'b0;
        do_write(20'h0, 16'h00C0, "R5 prot setup");
        do_write(20'h70004, 16'h1357, "R5 prot data");
        busy = 1'b0;
        do_write(20'h0, 16'h0040, "R5 word setup 40");
        do_write(20'h00808, 16'hD0D0, "R5 word data D0D0");
        busy = 1'b0;

        // R12 status capture and hold
        rd_en = 1'b1; rd_addr = 20'h0;
        tick();
        check("R12 status captured", {16'd0, rd_data}, 32'h0080);
        busy = 1'b1;
        tick();
        check("R12 status held while strobe high", {16'd0, rd_data}, 32'h0080);
        rd_en = 1'b0;
        tick();
        check("R1 zero after strobe low", {16'd0, rd_data}, 32'd0);
        rd_en = 1'b1;
        tick();
        check("R12 new status after re-strobe", {16'd0, rd_data}, 32'h0000);
        rd_en = 1'b0;
        busy = 1'b0;
        tick();

        // R2 read and mode write in the same clock
        do_write(20'h0, 16'h00FF, "R2 back to array");
        wr_en = 1'b1; wr_data = 16'h0070; wr_addr = 20'h0;
        rd_en = 1'b1; rd_addr = 20'h00321;
        tick();
        wr_en = 1'b0; rd_en = 1'b0;
        m_mode = 3;
        check("R2 same-clock read uses old mode", {16'd0, rd_data}, {16'd0, 16'h0321 ^ 16'hA5A5});
        tick();
        do_read(20'h0, "R2 status after same-clock write");

        // random phase
        for (int it = 0; it < 600; it++) begin
            if (busy && !m_susp && ($urandom % 4 == 0)) busy = 1'b0;
            if ($urandom % 5 < 3)
                do_write(20'($urandom), {8'($urandom), pick_op()}, "R2-random write");
            else
                do_read(pick_raddr(), "R3 R11 random read");
        end

        done = 1'b1;
        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

endmodule